// File: doc/BRIEF.md
# Bit-Field and Byte-Reorder Unit

This block is a purely combinational 32-bit datapath for bit manipulation, meant to sit beside the main ALU of a processor execute stage. A 4-bit operation code selects one result. It can mirror the source bit order, reverse the byte order of the whole word, or swap the bytes inside each 16-bit half. It can also swap the bytes of the low half and sign-extend the result. Other codes clear or insert a bit field in the destination value, rotate the source right by whole bytes and then sign- or zero-extend its low byte or half, or load a 16-bit immediate into the low or high half of the word.

The caller supplies the source operand, the current destination value and the immediate fields: field start, field length, byte-rotate count and the 16-bit immediate. Each field goes only to the operations that use it. The result follows the inputs in the same cycle, with no register on the way. Flags, register write-back and the trapping of illegal fields belong to the surrounding pipeline.

Top module: `bfr_unit`

## Requirements
- R1: Code 0 (bit mirror) drives result bit i from source bit 31-i. Source 0x12345678 gives 0x1E6A2C48.
- R2: Code 1 (word byte reverse) places source byte k at byte 3-k. Source 0x12345678 gives 0x78563412.
- R3: Code 2 (half byte swap) exchanges the two bytes within each 16-bit half independently. Source 0x12345678 gives 0x34127856.
- R4: Code 3 (signed half swap) swaps the two bytes of source bits 15:0 and fills bits 31:16 with copies of the new bit 15, which is source bit 7. 0x33448899 gives 0xFFFF9988.
- R5: Code 4 (field clear) returns the destination value with bits fld_lsb through fld_lsb+fld_width-1 forced to 0 and every other bit unchanged.
- R6: Code 5 (field insert) returns the destination value with bits fld_lsb through fld_lsb+fld_width-1 replaced by source bits fld_width-1:0. All other bits keep their destination value.
- R7: Codes 6, 7, 8 and 9 first rotate the source right by 8*rot_sel bits. They then extend the low part of the rotated value: code 6 sign-extends the low byte, code 7 sign-extends the low half, code 8 zero-extends the low byte and code 9 zero-extends the low half. Source 0x55AA8765 with rot_sel 0 gives 0x00000065, 0xFFFF8765, 0x00000065 and 0x00008765 for the four codes.
- R8: Code 10 (load low) returns the immediate in bits 15:0 with bits 31:16 zero, whatever the destination value is.
- R9: Code 11 (load high) returns the immediate in bits 31:16 and keeps destination bits 15:0. A load low followed by a load high therefore builds a full 32-bit constant. The reverse order loses the high half.
- R10: Codes 12 to 15 are unused and give a result of 0.
- R11: The result is combinational. It reflects a change on any input without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, values 0 to 11 as in the requirements |
| src_val | input | 32 | Source operand |
| dst_val | input | 32 | Current destination value, used by field clear/insert and load high |
| fld_lsb | input | 5 | Lowest bit of the field |
| fld_width | input | 6 | Field length in bits, 1 to 32 |
| rot_sel | input | 2 | Byte-rotate count applied before extension |
| imm_half | input | 16 | Immediate for the low/high loads |
| result | output | 32 | Selected result |

## Verification
The field assertions rely on a legal field: fld_width of at least 1 and fld_lsb+fld_width no more than 32. They are gated on a named legality wire, so they stay quiet for other values. The stimulus respects the same rule. Its random cases draw the width first and then choose a start bit from the positions that still fit. The table vectors include both edges: a full 32-bit field at bit 0 and a one-bit field at bit 31. Rotate counts cover all four byte positions. Random opcodes are drawn from the whole 4-bit space, so the unused codes are exercised as well.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_BIT_MIRROR   = 4'd0,
    OP_WORD_BSWAP   = 4'd1,
    OP_HALF_BSWAP   = 4'd2,
    OP_HALF_BSWAP_S = 4'd3,
    OP_FIELD_CLR    = 4'd4,
    OP_FIELD_INS    = 4'd5,
    OP_EXT_S8       = 4'd6,
    OP_EXT_S16      = 4'd7,
    OP_EXT_U8       = 4'd8,
    OP_EXT_U16      = 4'd9,
    OP_LOAD_LO      = 4'd10,
    OP_LOAD_HI      = 4'd11
  } bfr_op_e;

endpackage

// File: rtl/bfr_reorder.sv
module bfr_reorder
  import bfr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] bit_mirror,
  output logic [DATA_W-1:0] word_bswap,
  output logic [DATA_W-1:0] half_bswap,
  output logic [DATA_W-1:0] half_bswap_sx
);

  localparam int NUM_BYTES  = DATA_W / BYTE_W;
  localparam int HALF_BYTES = HALF_W / BYTE_W;
  localparam int NUM_HALVES = DATA_W / HALF_W;

  // bit mirror
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign bit_mirror[i] = src[DATA_W-1-i];
  end

  // byte reverse across the whole word
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_word
    assign word_bswap[b*BYTE_W +: BYTE_W] = src[(NUM_BYTES-1-b)*BYTE_W +: BYTE_W];
  end

  // byte reverse inside each half, halves kept in place
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    for (genvar k = 0; k < HALF_BYTES; k++) begin : g_byte
      assign half_bswap[(h*HALF_BYTES+k)*BYTE_W +: BYTE_W] =
        src[(h*HALF_BYTES+HALF_BYTES-1-k)*BYTE_W +: BYTE_W];
    end
  end

  // low half swapped then sign-filled upward
  assign half_bswap_sx = {{(DATA_W-HALF_W){half_bswap[HALF_W-1]}}, half_bswap[HALF_W-1:0]};

  always_comb begin
    p_mirror_pop_r1: assert ($countones(bit_mirror) == $countones(src))
      else $error("bit mirror changed the population count");
    p_mirror_ends_r1: assert (bit_mirror[0] == src[DATA_W-1] && bit_mirror[DATA_W-1] == src[0])
      else $error("bit mirror end bits wrong");
    if (DATA_W == 2*HALF_W) begin
      p_word_vs_half_r2: assert ({word_bswap[HALF_W-1:0], word_bswap[DATA_W-1:HALF_W]} == half_bswap)
        else $error("word reverse disagrees with per-half swap");
    end
    p_half_pop_r3: assert ($countones(half_bswap) == $countones(src))
      else $error("half swap changed the population count");
    p_sx_fill_r4: assert (half_bswap_sx[HALF_W-1:0] == half_bswap[HALF_W-1:0] &&
                          half_bswap_sx[HALF_W-1] == src[BYTE_W-1] &&
                          ($countones(half_bswap_sx[DATA_W-1:HALF_W]) == 0 ||
                           $countones(half_bswap_sx[DATA_W-1:HALF_W]) == DATA_W-HALF_W))
      else $error("signed half swap fill wrong");
  end

endmodule

// File: rtl/bfr_field.sv
module bfr_field
  import bfr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LSB_W = $clog2(DATA_W),
  localparam int WID_W = LSB_W + 1
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [LSB_W-1:0]  lsb,
  input  logic [WID_W-1:0]  width,
  output logic [DATA_W-1:0] clr_res,
  output logic [DATA_W-1:0] ins_res
);

  localparam logic [DATA_W:0] ONE_X = {{DATA_W{1'b0}}, 1'b1};

  // ones in the low `w` positions; w may equal DATA_W
  function automatic logic [DATA_W-1:0] low_ones(input logic [WID_W-1:0] w);
    logic [DATA_W:0] t;
    t = (ONE_X << w) - ONE_X;
    return t[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] fld_mask;
  logic [DATA_W-1:0] placed;
  logic              fld_legal;

  assign low_mask  = low_ones(width);
  assign fld_mask  = low_mask << lsb;
  assign placed    = src << lsb;
  assign fld_legal = (width != '0) && (int'(lsb) + int'(width) <= DATA_W);

  assign clr_res = dst & ~fld_mask;
  assign ins_res = (dst & ~fld_mask) | (placed & fld_mask);

  always_comb begin
    if (fld_legal) begin
      p_clr_keep_r5: assert (((clr_res ^ dst) & ~fld_mask) == '0)
        else $error("field clear touched bits outside the field");
      p_clr_pop_r5: assert ($countones(clr_res) + $countones(dst & fld_mask) == $countones(dst))
        else $error("field clear left field bits set");
      p_ins_keep_r6: assert (((ins_res ^ dst) & ~fld_mask) == '0)
        else $error("field insert touched bits outside the field");
      p_ins_payload_r6: assert (((ins_res >> lsb) & low_mask) == (src & low_mask))
        else $error("field insert payload wrong");
      p_mask_size_r5: assert ($countones(fld_mask) == int'(width))
        else $error("field mask size wrong");
    end
  end

endmodule

// File: rtl/bfr_extend.sv
module bfr_extend
  import bfr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int ROT_W = $clog2(NUM_BYTES)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [ROT_W-1:0]  rot,
  output logic [DATA_W-1:0] ext_s8,
  output logic [DATA_W-1:0] ext_s16,
  output logic [DATA_W-1:0] ext_u8,
  output logic [DATA_W-1:0] ext_u16
);

  // rotate right by whole bytes
  function automatic logic [DATA_W-1:0] rotr_bytes(input logic [DATA_W-1:0] v,
                                                   input logic [ROT_W-1:0] n);
    logic [2*DATA_W-1:0] dbl;
    dbl = {v, v} >> (int'(n) * BYTE_W);
    return dbl[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] rotated;
  assign rotated = rotr_bytes(src, rot);

  assign ext_s8  = {{(DATA_W-BYTE_W){rotated[BYTE_W-1]}}, rotated[BYTE_W-1:0]};
  assign ext_s16 = {{(DATA_W-HALF_W){rotated[HALF_W-1]}}, rotated[HALF_W-1:0]};
  assign ext_u8  = {{(DATA_W-BYTE_W){1'b0}}, rotated[BYTE_W-1:0]};
  assign ext_u16 = {{(DATA_W-HALF_W){1'b0}}, rotated[HALF_W-1:0]};

  always_comb begin
    p_rot_pop_r7: assert ($countones(rotated) == $countones(src))
      else $error("byte rotation changed the population count");
    p_low_agree_r7: assert (ext_s8[BYTE_W-1:0] == ext_u8[BYTE_W-1:0] &&
                            ext_s16[HALF_W-1:0] == ext_u16[HALF_W-1:0])
      else $error("signed and unsigned extensions disagree in the low part");
    p_zero_fill_r7: assert (ext_u8[DATA_W-1:BYTE_W] == '0 && ext_u16[DATA_W-1:HALF_W] == '0)
      else $error("zero extension left upper bits set");
    p_sign_fill_r7: assert (($countones(ext_s8[DATA_W-1:BYTE_W]) == 0) == !ext_s8[BYTE_W-1] &&
                            ($countones(ext_s16[DATA_W-1:HALF_W]) == 0) == !ext_s16[HALF_W-1])
      else $error("sign extension fill wrong");
    if (rot == '0) begin
      p_no_rot_r7: assert (ext_u16[HALF_W-1:0] == src[HALF_W-1:0])
        else $error("zero rotate altered the low half");
    end
  end

endmodule

// File: rtl/bfr_movimm.sv
module bfr_movimm
  import bfr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [HALF_W-1:0] imm,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] lo_res,
  output logic [DATA_W-1:0] hi_res
);

  assign lo_res = {{(DATA_W-HALF_W){1'b0}}, imm};
  assign hi_res = {imm, dst[DATA_W-HALF_W-1:0]};

  always_comb begin
    p_lo_clears_top_r8: assert ($countones(lo_res) == $countones(imm))
      else $error("load low left stray upper bits");
    p_hi_keeps_low_r9: assert (hi_res[DATA_W-HALF_W-1:0] == dst[DATA_W-HALF_W-1:0] &&
                               hi_res[DATA_W-1:DATA_W-HALF_W] == lo_res[HALF_W-1:0])
      else $error("load high did not merge as expected");
  end

endmodule

// File: rtl/bfr_unit.sv
module bfr_unit
  import bfr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LSB_W = $clog2(DATA_W),
  localparam int WID_W = LSB_W + 1,
  localparam int ROT_W = $clog2(DATA_W / BYTE_W)
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [LSB_W-1:0]  fld_lsb,
  input  logic [WID_W-1:0]  fld_width,
  input  logic [ROT_W-1:0]  rot_sel,
  input  logic [HALF_W-1:0] imm_half,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] r_mirror, r_wswap, r_hswap, r_hswap_sx;
  logic [DATA_W-1:0] r_clr, r_ins;
  logic [DATA_W-1:0] r_s8, r_s16, r_u8, r_u16;
  logic [DATA_W-1:0] r_lo, r_hi;
  logic              op_known;

  bfr_reorder #(.DATA_W(DATA_W)) u_reorder (
    .src           (src_val),
    .bit_mirror    (r_mirror),
    .word_bswap    (r_wswap),
    .half_bswap    (r_hswap),
    .half_bswap_sx (r_hswap_sx)
  );

  bfr_field #(.DATA_W(DATA_W)) u_field (
    .dst     (dst_val),
    .src     (src_val),
    .lsb     (fld_lsb),
    .width   (fld_width),
    .clr_res (r_clr),
    .ins_res (r_ins)
  );

  bfr_extend #(.DATA_W(DATA_W)) u_extend (
    .src     (src_val),
    .rot     (rot_sel),
    .ext_s8  (r_s8),
    .ext_s16 (r_s16),
    .ext_u8  (r_u8),
    .ext_u16 (r_u16)
  );

  bfr_movimm #(.DATA_W(DATA_W)) u_movimm (
    .imm    (imm_half),
    .dst    (dst_val),
    .lo_res (r_lo),
    .hi_res (r_hi)
  );

  assign op_known = (op_sel <= OP_LOAD_HI);

  always_comb begin
    unique case (bfr_op_e'(op_sel))
      OP_BIT_MIRROR:   result = r_mirror;
      OP_WORD_BSWAP:   result = r_wswap;
      OP_HALF_BSWAP:   result = r_hswap;
      OP_HALF_BSWAP_S: result = r_hswap_sx;
      OP_FIELD_CLR:    result = r_clr;
      OP_FIELD_INS:    result = r_ins;
      OP_EXT_S8:       result = r_s8;
      OP_EXT_S16:      result = r_s16;
      OP_EXT_U8:       result = r_u8;
      OP_EXT_U16:      result = r_u16;
      OP_LOAD_LO:      result = r_lo;
      OP_LOAD_HI:      result = r_hi;
      default:         result = '0;
    endcase
  end

  always_comb begin
    if (!op_known) begin
      p_unused_zero_r10: assert (result == '0)
        else $error("unused code produced a non-zero result");
    end
    if (op_sel == OP_LOAD_LO) begin
      p_lo_ignores_dst_r8: assert (result[DATA_W-1:HALF_W] == '0)
        else $error("load low result carries destination bits");
    end
  end

endmodule

// File: tb/bfr_unit_tb_top.sv
module bfr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] src_val = '0;
  logic [31:0] dst_val = '0;
  logic [4:0]  fld_lsb = '0;
  logic [5:0]  fld_width = 6'd1;
  logic [1:0]  rot_sel = '0;
  logic [15:0] imm_half = '0;
  logic [31:0] result;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bfr_unit dut_i (
    .op_sel    (op_sel),
    .src_val   (src_val),
    .dst_val   (dst_val),
    .fld_lsb   (fld_lsb),
    .fld_width (fld_width),
    .rot_sel   (rot_sel),
    .imm_half  (imm_half),
    .result    (result)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] s;
    logic [31:0] d;
    logic [4:0]  l;
    logic [5:0]  w;
    logic [1:0]  r;
    logic [15:0] i;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  32'h12345678, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'h1E6A2C48},
    '{4'd1,  32'h12345678, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'h78563412},
    '{4'd2,  32'h12345678, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'h34127856},
    '{4'd3,  32'h33448899, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'hFFFF9988},
    '{4'd3,  32'h12345678, 32'hFFFFFFFF, 5'd0,  6'd1,  2'd0, 16'h0,    32'h00007856},
    '{4'd4,  32'h0,        32'hFFFFFFFF, 5'd8,  6'd12, 2'd0, 16'h0,    32'hFFF000FF},
    '{4'd4,  32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0,  6'd32, 2'd0, 16'h0,    32'h00000000},
    '{4'd5,  32'h00000ABC, 32'hFFFFFFFF, 5'd8,  6'd12, 2'd0, 16'h0,    32'hFFFABCFF},
    '{4'd5,  32'hFFFFFFFF, 32'h00000000, 5'd31, 6'd1,  2'd0, 16'h0,    32'h80000000},
    '{4'd6,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'h00000065},
    '{4'd7,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'hFFFF8765},
    '{4'd8,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'h00000065},
    '{4'd9,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd0, 16'h0,    32'h00008765},
    '{4'd6,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd1, 16'h0,    32'hFFFFFF87},
    '{4'd9,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd2, 16'h0,    32'h000055AA},
    '{4'd7,  32'h55AA8765, 32'h0,        5'd0,  6'd1,  2'd3, 16'h0,    32'h00006555},
    '{4'd10, 32'h0,        32'hFFFFFFFF, 5'd0,  6'd1,  2'd0, 16'h4321, 32'h00004321},
    '{4'd11, 32'h0,        32'h00004321, 5'd0,  6'd1,  2'd0, 16'h8765, 32'h87654321},
    '{4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0,  6'd1,  2'd0, 16'hFFFF, 32'h00000000},
    '{4'd15, 32'h12345678, 32'hFFFFFFFF, 5'd4,  6'd4,  2'd3, 16'h1234, 32'h00000000}
  };

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7, 4'd8, 4'd9: return "R7";
      4'd10: return "R8";
      4'd11: return "R9";
      default: return "R10";
    endcase
  endfunction

  // independent reference, written bit by bit
  function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] s,
                                            input logic [31:0] d, input int l, input int w,
                                            input int r, input logic [15:0] im);
    logic [31:0] o, rs;
    o = '0;
    rs = s;
    for (int k = 0; k < r * 8; k++) rs = {rs[0], rs[31:1]};
    case (op)
      4'd0: for (int k = 0; k < 32; k++) o[k] = s[31-k];
      4'd1: for (int k = 0; k < 4; k++) o[8*k +: 8] = s[8*(3-k) +: 8];
      4'd2: o = {s[23:16], s[31:24], s[7:0], s[15:8]};
      4'd3: o = {{16{s[7]}}, s[7:0], s[15:8]};
      4'd4: begin o = d; for (int k = l; k < l + w; k++) o[k] = 1'b0; end
      4'd5: begin o = d; for (int k = 0; k < w; k++) o[l+k] = s[k]; end
      4'd6: o = {{24{rs[7]}}, rs[7:0]};
      4'd7: o = {{16{rs[15]}}, rs[15:0]};
      4'd8: o = {24'h0, rs[7:0]};
      4'd9: o = {16'h0, rs[15:0]};
      4'd10: o = {16'h0, im};
      4'd11: o = {im, d[15:0]};
      default: o = '0;
    endcase
    return o;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] s, input logic [31:0] d,
                       input logic [4:0] l, input logic [5:0] w, input logic [1:0] r,
                       input logic [15:0] im);
    @(negedge clk);
    op_sel = op; src_val = s; dst_val = d; fld_lsb = l; fld_width = w;
    rot_sel = r; imm_half = im;
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] tmp;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all-zero inputs on code 0 give a zero result (R1)
    check("R1 idle", result, 32'h0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].op, TBL[k].s, TBL[k].d, TBL[k].l, TBL[k].w, TBL[k].r, TBL[k].i);
      check(op_tag(TBL[k].op), result, TBL[k].e);
    end

    // R8: destination value ignored by load low
    drive(4'd10, 32'hDEADBEEF, 32'hA5A5A5A5, 5'd3, 6'd7, 2'd2, 16'hBEEF);
    check("R8 dst ignored", result, 32'h0000BEEF);

    // R9: order of the two loads
    drive(4'd10, 32'h0, 32'h0, 5'd0, 6'd1, 2'd0, 16'h4321);
    tmp = result;
    drive(4'd11, 32'h0, tmp, 5'd0, 6'd1, 2'd0, 16'h8765);
    check("R9 low then high", result, 32'h87654321);
    drive(4'd11, 32'h0, 32'h0, 5'd0, 6'd1, 2'd0, 16'h8765);
    tmp = result;
    drive(4'd10, 32'h0, tmp, 5'd0, 6'd1, 2'd0, 16'h4321);
    check("R9 high then low", result, 32'h00004321);

    // R11: two changes between clock edges, each visible at once
    @(negedge clk);
    op_sel = 4'd1; src_val = 32'hAABBCCDD;
    #0.5;
    check("R11 first change", result, 32'hDDCCBBAA);
    src_val = 32'h01020304;
    #0.5;
    check("R11 second change", result, 32'h04030201);

    // randomized legal cases against the reference model
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      logic [31:0] s, d;
      logic [15:0] im;
      int w, l, r;
      op = 4'($urandom_range(0, 15));
      s = $urandom;
      d = $urandom;
      im = 16'($urandom);
      w = $urandom_range(1, 32);
      l = $urandom_range(0, 32 - w);
      r = $urandom_range(0, 3);
      drive(op, s, d, 5'(l), 6'(w), 2'(r), im);
      check(op_tag(op), result, ref_model(op, s, d, l, w, r, im));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule